// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs bus cycles to four external chip-select areas. Each cycle's length in bus clocks comes from three settings. The first is a global software-wait enable. The second is a no-wait select for each area. The third is a 2-bit wait-count field for each area. The bus-mode select of the area (separate or multiplexed address/data) also changes the length.

A requester raises `req_i` for one clock while the block is idle, with the area index and the direction. The block then drives that area's chip-select for the whole cycle. It asserts the read or write strobe from the second clock of the cycle, or in the single clock of a no-wait read. It ends the cycle with a one-clock `done_o` pulse.

After the programmed wait states, the active-low ready input can stretch a cycle further. It does so only when the area uses wait states. The configuration is sampled when the request is accepted. An illegal setting is forced to a one-wait cycle and raises a flag for the length of that cycle.

Top module: `ext_wait_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `rd_o`, `wr_o`, `cfg_err_o` and every bit of `cs_o` are 0.
- R2: On a separate bus (`mux_mode_i` bit 0) with `sw_wait_en_i`=0 and the area's `no_wait_i` bit at 1, a read lasts 1 bus clock and a write lasts 2 bus clocks.
- R3: On a separate bus with the `no_wait_i` bit at 0, a wait-count of 00b gives 2 bus clocks, 01b gives 3 and 10b gives 4.
- R4: With `sw_wait_en_i`=1, cycle lengths follow the wait-count as in R3 and R5. A `no_wait_i` bit at 1 is then illegal and is handled as wait-count 00b with wait states.
- R5: On a multiplexed bus (`mux_mode_i` bit 1) wait-counts 00b and 01b give 3 bus clocks and 10b gives 4. A `no_wait_i` bit at 1 is illegal there and gives 3 bus clocks.
- R6: Wait-count 11b behaves exactly like 10b.
- R7: In a wait-state cycle, each bus clock at or after the programmed length in which `rdy_ni` is 1 adds one clock. The cycle ends in the first clock where `rdy_ni` is 0. In a no-wait cycle `rdy_ni` has no effect.
- R8: During a cycle exactly one `cs_o` bit is high: bit `area_i` as sampled at acceptance. It holds until the cycle ends, and `cs_o` is 0 when idle.
- R9: `wr_o` is high during a write and `rd_o` during a read, from the cycle's second clock to its last. A no-wait read asserts `rd_o` in its only clock. The two strobes are never high together.
- R10: A request is accepted only when `busy_o` is 0. A request made during a cycle changes neither that cycle nor what follows it.
- R11: `done_o` is high for exactly one clock, the last clock of the cycle, and `busy_o` is 0 in the next clock.
- R12: `cfg_err_o` is high through a cycle accepted with an illegal configuration (R4, R5) and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_wait_en_i | input | 1 | Global software-wait enable |
| no_wait_i | input | 4 | Per-area no-wait select |
| wait_cnt_i | input | 8 | Per-area wait-count, area n at bits [2n+1:2n] |
| mux_mode_i | input | 4 | Per-area bus mode, 1 = multiplexed |
| req_i | input | 1 | Cycle request strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| area_i | input | 2 | Target area index |
| rdy_ni | input | 1 | External ready, active low |
| cs_o | output | 4 | Chip-selects, one per area |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Last-clock pulse of a cycle |
| cfg_err_o | output | 1 | Illegal configuration for the current cycle |

## Verification
Directed accesses cover each wait-count code on both bus modes. These separate the multiplexed one-wait promotion from the separate-bus one-wait cycle, and 11b from 10b. No-wait reads and writes are compared against their wait-state counterparts to confirm that the direction changes only the no-wait length. Illegal combinations with the global enable and with multiplexed mode show the forced length and the error flag. Random configurations with zero to three ready-held clocks show that ready stretching stacks on the programmed length and is ignored in no-wait cycles. Requests raised mid-cycle test that acceptance waits for idle.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  localparam int WC_W  = 2;
  localparam int LEN_W = 3;

  typedef struct packed {
    logic             nowait;
    logic             err;
    logic [LEN_W-1:0] len;
  } cyc_cfg_t;

  function automatic cyc_cfg_t decode_cfg(input logic sw_en, input logic nw,
                                          input logic mux, input logic wr,
                                          input logic [WC_W-1:0] wc);
    cyc_cfg_t         c;
    logic [LEN_W-1:0] waits;
    c.err    = nw & (mux | sw_en);
    c.nowait = nw & ~mux & ~sw_en;
    if (c.err)             waits = LEN_W'(1);
    else if (wc == 2'b11)  waits = LEN_W'(3);  // reserved code aliases 10b
    else                   waits = LEN_W'(wc) + LEN_W'(1);
    if (mux && waits == LEN_W'(1)) waits = LEN_W'(2);
    if (c.nowait) c.len = wr ? LEN_W'(2) : LEN_W'(1);
    else          c.len = waits + LEN_W'(1);
    return c;
  endfunction
endpackage

// File: rtl/ewc_cfg_sel.sv
module ewc_cfg_sel
  import ewc_pkg::*;
#(
  parameter int N_AREA = 4,
  localparam int AREA_W = $clog2(N_AREA)
) (
  input  logic                   sw_wait_en_i,
  input  logic [N_AREA-1:0]      no_wait_i,
  input  logic [N_AREA*WC_W-1:0] wait_cnt_i,
  input  logic [N_AREA-1:0]      mux_mode_i,
  input  logic                   wr_i,
  input  logic [AREA_W-1:0]      area_i,
  output cyc_cfg_t               cfg_o
);
  logic [WC_W-1:0] wc_sel;

  assign wc_sel = wait_cnt_i[area_i*WC_W +: WC_W];
  assign cfg_o  = decode_cfg(sw_wait_en_i, no_wait_i[area_i],
                             mux_mode_i[area_i], wr_i, wc_sel);
endmodule

// File: rtl/ewc_seq.sv
module ewc_seq
  import ewc_pkg::*;
#(
  parameter int N_AREA = 4,
  localparam int AREA_W = $clog2(N_AREA)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [AREA_W-1:0] area_i,
  input  cyc_cfg_t          cfg_i,
  input  logic              rdy_ni,
  output logic              busy_o,
  output logic [LEN_W-1:0]  cnt_o,
  output logic              wr_q_o,
  output logic [AREA_W-1:0] area_q_o,
  output logic              nowait_q_o,
  output logic              err_q_o,
  output logic              done_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0] len_q;
  logic             accept;

  assign accept = req_i & ~busy_o;
  // ready matters only once the programmed length is reached
  assign done_o = busy_o & (cnt_o >= len_q) & (nowait_q_o | ~rdy_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      cnt_o      <= '0;
      len_q      <= '0;
      wr_q_o     <= 1'b0;
      area_q_o   <= '0;
      nowait_q_o <= 1'b0;
      err_q_o    <= 1'b0;
    end else if (accept) begin
      busy_o     <= 1'b1;
      cnt_o      <= LEN_W'(1);
      len_q      <= cfg_i.len;
      wr_q_o     <= wr_i;
      area_q_o   <= area_i;
      nowait_q_o <= cfg_i.nowait;
      err_q_o    <= cfg_i.err;
    end else if (done_o) begin
      busy_o  <= 1'b0;
      cnt_o   <= '0;
      err_q_o <= 1'b0;
    end else if (busy_o && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + LEN_W'(1);
    end
  end
endmodule

// File: rtl/ewc_out.sv
module ewc_out
  import ewc_pkg::*;
#(
  parameter int N_AREA = 4,
  localparam int AREA_W = $clog2(N_AREA)
) (
  input  logic              busy_i,
  input  logic [LEN_W-1:0]  cnt_i,
  input  logic              wr_q_i,
  input  logic [AREA_W-1:0] area_q_i,
  input  logic              nowait_q_i,
  output logic [N_AREA-1:0] cs_o,
  output logic              rd_o,
  output logic              wr_o
);
  logic strobe_win;

  for (genvar g = 0; g < N_AREA; g++) begin : g_cs
    assign cs_o[g] = busy_i & (area_q_i == AREA_W'(g));
  end

  assign strobe_win = busy_i & (cnt_i >= LEN_W'(2));
  assign rd_o = ~wr_q_i & (strobe_win | (busy_i & nowait_q_i));
  assign wr_o = wr_q_i & strobe_win;
endmodule

// File: rtl/ext_wait_ctrl.sv
module ext_wait_ctrl
  import ewc_pkg::*;
#(
  parameter int N_AREA = 4,
  localparam int AREA_W = $clog2(N_AREA)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sw_wait_en_i,
  input  logic [N_AREA-1:0]      no_wait_i,
  input  logic [N_AREA*WC_W-1:0] wait_cnt_i,
  input  logic [N_AREA-1:0]      mux_mode_i,
  input  logic                   req_i,
  input  logic                   wr_i,
  input  logic [AREA_W-1:0]      area_i,
  input  logic                   rdy_ni,
  output logic [N_AREA-1:0]      cs_o,
  output logic                   rd_o,
  output logic                   wr_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   cfg_err_o
);
  cyc_cfg_t          cfg;
  logic [LEN_W-1:0]  cnt;
  logic              wr_q, nowait_q, err_q;
  logic [AREA_W-1:0] area_q;

  ewc_cfg_sel #(.N_AREA(N_AREA)) u_cfg (
    .sw_wait_en_i(sw_wait_en_i), .no_wait_i(no_wait_i),
    .wait_cnt_i(wait_cnt_i), .mux_mode_i(mux_mode_i),
    .wr_i(wr_i), .area_i(area_i), .cfg_o(cfg)
  );

  ewc_seq #(.N_AREA(N_AREA)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i),
    .area_i(area_i), .cfg_i(cfg), .rdy_ni(rdy_ni), .busy_o(busy_o),
    .cnt_o(cnt), .wr_q_o(wr_q), .area_q_o(area_q),
    .nowait_q_o(nowait_q), .err_q_o(err_q), .done_o(done_o)
  );

  ewc_out #(.N_AREA(N_AREA)) u_out (
    .busy_i(busy_o), .cnt_i(cnt), .wr_q_i(wr_q), .area_q_i(area_q),
    .nowait_q_i(nowait_q), .cs_o(cs_o), .rd_o(rd_o), .wr_o(wr_o)
  );

  assign cfg_err_o = busy_o & err_q;
endmodule

// File: rtl/ewc_chk.sv
module ewc_chk #(
  parameter int N_AREA = 4,
  localparam int AREA_W = $clog2(N_AREA)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [N_AREA-1:0] cs_o,
  input logic              rd_o,
  input logic              wr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              cfg_err_o
);
  p_rst_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |=> !busy_o || !rst_ni);
  p_cs_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  p_busy_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (cs_o != '0));
  p_cs_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> $stable(cs_o));
  p_strobe_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> busy_o);
  p_rdwr_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o |=> busy_o);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  p_err_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> busy_o);
endmodule

bind ext_wait_ctrl ewc_chk #(.N_AREA(N_AREA)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .cs_o(cs_o),
  .rd_o(rd_o), .wr_o(wr_o), .busy_o(busy_o), .done_o(done_o),
  .cfg_err_o(cfg_err_o)
);

// File: tb/ext_wait_ctrl_tb.sv
module ext_wait_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_en = 1'b0, req = 1'b0, wr = 1'b0, rdy_n = 1'b0;
  logic [3:0] nw = '0, mux = '0, cs;
  logic [7:0] wc = '0;
  logic [1:0] area = '0;
  logic       rd_s, wr_s, busy, done, err;
  int         n_chk = 0, n_err = 0;
  bit         wd_hit = 0;

  always #10 clk = ~clk;

  ext_wait_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_wait_en_i(sw_en), .no_wait_i(nw),
    .wait_cnt_i(wc), .mux_mode_i(mux), .req_i(req), .wr_i(wr),
    .area_i(area), .rdy_ni(rdy_n), .cs_o(cs), .rd_o(rd_s), .wr_o(wr_s),
    .busy_o(busy), .done_o(done), .cfg_err_o(err)
  );

  task automatic check(string req_id, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req_id, act, exp, $time);
    end
  endtask

  function automatic bit f_err(bit s, bit n, bit m);
    return n && (m || s);
  endfunction

  function automatic bit f_nowait(bit s, bit n, bit m);
    return n && !m && !s;
  endfunction

  function automatic int f_len(bit s, bit n, bit m, bit w, logic [1:0] c);
    int waits;
    if (f_nowait(s, n, m)) return w ? 2 : 1;          // R2
    if (f_err(s, n, m)) waits = 1;                    // R4, R5
    else waits = (c == 2'b11) ? 3 : int'(c) + 1;      // R3, R6
    if (m && waits == 1) waits = 2;                   // R5
    return waits + 1;
  endfunction

  // one access; extra = clocks rdy_n held high past the programmed length
  task automatic access(bit s, logic [3:0] n, logic [3:0] m, logic [7:0] c,
                        logic [1:0] a, bit w, int extra, bit poke, string tag);
    int  base, tot;
    bit  nwt, e;
    nwt  = f_nowait(s, n[a], m[a]);
    e    = f_err(s, n[a], m[a]);
    base = f_len(s, n[a], m[a], w, c[2*a +: 2]);
    tot  = nwt ? base : base + extra;
    @(negedge clk);
    sw_en = s; nw = n; mux = m; wc = c; area = a; wr = w; req = 1'b1; rdy_n = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      req = poke && (k == 1);                          // R10 request while busy
      if (poke && k == 1) begin area = a + 2'd1; wr = ~w; end
      rdy_n = (k < base + extra);
      #1;
      check({tag, " R8 cs"}, int'(cs), 1 << a);
      check({tag, " R9 rd"}, int'(rd_s), int'(!w && (k >= 2 || nwt)));
      check({tag, " R9 wr"}, int'(wr_s), int'(w && k >= 2));
      check({tag, " R12 err"}, int'(err), int'(e));
      check({tag, " R11 done"}, int'(done), int'(k == tot));
      if (k == tot) break;
    end
    @(negedge clk);
    req = 1'b0; rdy_n = 1'b1;
    #1;
    check({tag, " R11 idle after done"}, int'(busy), 0);
    check({tag, " R10 no stray cycle"}, int'(cs), 0);
  endtask

  initial begin
    #2000000;
    wd_hit = 1;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    #35;
    check("R1 busy", int'(busy), 0);
    check("R1 cs", int'(cs), 0);
    check("R1 strobes", int'(rd_s | wr_s | done | err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 still idle", int'(busy), 0);
    // directed: reset defaults -> one wait
    access(0, 4'h0, 4'h0, 8'h00, 2'd0, 0, 0, 0, "R3 default");
    access(0, 4'h2, 4'h0, 8'h00, 2'd1, 0, 0, 0, "R2 nowait rd");
    access(0, 4'h2, 4'h0, 8'h00, 2'd1, 1, 0, 0, "R2 nowait wr");
    access(0, 4'h2, 4'h0, 8'h00, 2'd1, 0, 3, 0, "R7 nowait rdy ignored");
    access(0, 4'h0, 4'h0, 8'h40, 2'd3, 1, 0, 0, "R3 wc01");
    access(0, 4'h0, 4'h0, 8'h20, 2'd2, 0, 0, 0, "R3 wc10");
    access(0, 4'h0, 4'h0, 8'hC0, 2'd3, 0, 0, 0, "R6 wc11");
    access(1, 4'h1, 4'h0, 8'h03, 2'd0, 0, 0, 0, "R4 illegal sw");
    access(1, 4'h0, 4'h0, 8'h04, 2'd1, 1, 0, 0, "R4 sw wc01");
    access(0, 4'h0, 4'h4, 8'h00, 2'd2, 0, 0, 0, "R5 mux wc00");
    access(0, 4'h0, 4'h4, 8'h10, 2'd2, 1, 0, 0, "R5 mux wc01");
    access(0, 4'h0, 4'h4, 8'h20, 2'd2, 0, 0, 0, "R5 mux wc10");
    access(0, 4'h8, 4'h8, 8'h00, 2'd3, 1, 0, 0, "R5 illegal mux");
    access(0, 4'h0, 4'h0, 8'h00, 2'd0, 0, 2, 0, "R7 rdy stretch");
    access(0, 4'h0, 4'h0, 8'h00, 2'd1, 1, 1, 1, "R10 poke");
    for (int i = 0; i < 200; i++) begin
      access(bit'($urandom_range(0, 3) == 0), 4'($urandom), 4'($urandom),
             8'($urandom), 2'($urandom), bit'($urandom), $urandom_range(0, 3),
             bit'($urandom_range(0, 4) == 0), "rand");
      if (wd_hit) break;
    end
    if (wd_hit) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule